// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a CPU core. Registers 8 to 15 exist once. Registers 0 to 7 exist twice, as bank 0 and bank 1. Software sees one set of register numbers 0 to 15. In privileged mode a bank-select bit from the status register decides which copy of the low eight registers those numbers reach. In user mode the low registers always come from bank 0.

The block has two combinational read ports and one write port that takes effect on the clock edge. All three take a 4-bit register number. Register 0 of the active bank is also driven on its own output at all times, so that address arithmetic can use it as an index without taking a read port.

An extra port addresses the bank that is not currently active. It carries a 3-bit low-register number and has its own read data, write enable and write data. A trap handler can use it to save or restore the other bank's registers without switching banks. Register contents have no reset value, and reset leaves them unchanged.

Top module: `banked_regfile`

## Requirements
- R1: When `we_i` is 1 at a rising clock edge, `wd_i` is stored in the register that `wa_addr_i` names. From the next cycle it reads back on both `ra_data_o` and `rb_data_o`.
- R2: Registers 8 to 15 are a single shared copy. A value written to one of them reads back the same for every combination of `priv_i` and `bank_sel_i`.
- R3: With `priv_i`=1, registers 0 to 7 come from bank 0 when `bank_sel_i`=0 and from bank 1 when `bank_sel_i`=1. A write to a low register in one bank does not change that register in the other bank.
- R4: With `priv_i`=0, registers 0 to 7 always come from bank 0, whatever the value of `bank_sel_i`. This applies to both reads and writes.
- R5: The alternate port works on the low register `alt_addr_i` (0 to 7) in the bank opposite to the active one. `alt_data_o` reads that register. When `alt_we_i` is 1 at a clock edge, `alt_wd_i` is written into it.
- R6: `r0_data_o` always shows register 0 of the active bank, independent of the read addresses.
- R7: If a register is read in the same cycle that it is written, the read returns the value it held before the edge.
- R8: Asserting `rst_ni` does not change any register's contents.
- R9: A main-port write and an alternate-port write in the same cycle both take effect.
- R10: When `we_i` and `alt_we_i` are both 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes occur on the rising edge |
| rst_ni | input | 1 | Active-low reset; does not clear register contents |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| bank_sel_i | input | 1 | Bank-select bit; used only when `priv_i` is 1 |
| ra_addr_i | input | 4 | Register number for read port A |
| ra_data_o | output | 32 | Read port A data (combinational) |
| rb_addr_i | input | 4 | Register number for read port B |
| rb_data_o | output | 32 | Read port B data (combinational) |
| we_i | input | 1 | Write enable for the main write port |
| wa_addr_i | input | 4 | Register number for the main write port |
| wd_i | input | 32 | Write data for the main write port |
| r0_data_o | output | 32 | Register 0 of the active bank |
| alt_addr_i | input | 3 | Low-register number on the alternate port |
| alt_data_o | output | 32 | Read data from the inactive bank |
| alt_we_i | input | 1 | Write enable for the alternate port |
| alt_wd_i | input | 32 | Write data for the alternate port |

## Verification
Some properties are checked by assertions on every clock cycle:
- a write is visible on the next read of the same register, on the main port and on the alternate port;
- reads stay stable while no write occurs;
- in user mode the bank-select bit has no effect;
- `r0_data_o` matches port A whenever port A addresses register 0;
- after the active bank flips, what the alternate port showed reappears on the main port.

The bench scenarios cover what needs a history of several writes:
- bank isolation of register 3 across bank switches;
- visibility of the shared registers after mode changes;
- the old value returned on a read in the same cycle as a write;
- simultaneous writes on both ports;
- contents kept across a reset pulse.

// File: rtl/bgrf_pkg.sv
package bgrf_pkg;
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_NUM_LOW  = 8;
  localparam int DEF_NUM_HIGH = 8;

  typedef enum logic {
    BANK_0 = 1'b0,
    BANK_1 = 1'b1
  } bank_e;
endpackage

// File: rtl/bgrf_bank_sel.sv
// Resolves the active and alternate bank from mode and status bit.
module bgrf_bank_sel
  import bgrf_pkg::*;
(
  input  logic  priv_i,
  input  logic  bank_sel_i,
  output bank_e cur_bank_o,
  output bank_e alt_bank_o
);
  always_comb begin
    // user mode is pinned to bank 0
    cur_bank_o = (priv_i && bank_sel_i) ? BANK_1 : BANK_0;
    alt_bank_o = (cur_bank_o == BANK_1) ? BANK_0 : BANK_1;
  end
endmodule

// File: rtl/bgrf_map.sv
// Logical register number + bank -> physical slot.
// Slots: [0..L-1] bank 0, [L..2L-1] bank 1, [2L..] shared.
module bgrf_map
  import bgrf_pkg::*;
#(
  parameter int NUM_LOW  = DEF_NUM_LOW,
  parameter int NUM_HIGH = DEF_NUM_HIGH,
  parameter int ADDR_W   = $clog2(NUM_LOW + NUM_HIGH),
  parameter int PHYS_W   = $clog2(2 * NUM_LOW + NUM_HIGH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o
);
  localparam logic [ADDR_W-1:0] LOW_LIM     = ADDR_W'(NUM_LOW);
  localparam logic [PHYS_W-1:0] BANK1_BASE  = PHYS_W'(NUM_LOW);
  localparam logic [PHYS_W-1:0] SHARED_BASE = PHYS_W'(2 * NUM_LOW);

  logic [ADDR_W-1:0] high_off;
  assign high_off = addr_i - LOW_LIM;

  always_comb begin
    if (addr_i < LOW_LIM) begin
      phys_o = ((bank_i == BANK_1) ? BANK1_BASE : '0) + PHYS_W'(addr_i);
    end else begin
      phys_o = SHARED_BASE + PHYS_W'(high_off);
    end
  end
endmodule

// File: rtl/bgrf_store.sv
// Physical storage: no reset, NUM_WR edge writes, NUM_RD async reads.
module bgrf_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_PHYS = 24,
  parameter int PHYS_W   = $clog2(NUM_PHYS),
  parameter int NUM_RD   = 4,
  parameter int NUM_WR   = 2
) (
  input  logic              clk_i,
  input  logic [NUM_WR-1:0] we_i,
  input  logic [PHYS_W-1:0] waddr_i [NUM_WR],
  input  logic [DATA_W-1:0] wdata_i [NUM_WR],
  input  logic [PHYS_W-1:0] raddr_i [NUM_RD],
  output logic [DATA_W-1:0] rdata_o [NUM_RD]
);
  logic [DATA_W-1:0] mem_q [NUM_PHYS];

  // ports never share a slot by construction of the bank map
  always_ff @(posedge clk_i) begin
    for (int w = 0; w < NUM_WR; w++) begin
      if (we_i[w]) mem_q[waddr_i[w]] <= wdata_i[w];
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bgrf_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NUM_LOW  = DEF_NUM_LOW,
  parameter int NUM_HIGH = DEF_NUM_HIGH,
  localparam int ADDR_W  = $clog2(NUM_LOW + NUM_HIGH),
  localparam int LOW_W   = $clog2(NUM_LOW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic              bank_sel_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_addr_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] r0_data_o,
  input  logic [LOW_W-1:0]  alt_addr_i,
  output logic [DATA_W-1:0] alt_data_o,
  input  logic              alt_we_i,
  input  logic [DATA_W-1:0] alt_wd_i
);
  localparam int NUM_PHYS = 2 * NUM_LOW + NUM_HIGH;
  localparam int PHYS_W   = $clog2(NUM_PHYS);
  localparam int NUM_RD   = 4;
  localparam int NUM_WR   = 2;
  localparam int NUM_MAP  = NUM_RD + NUM_WR;
  // map slot order: reads first, then writes
  localparam int M_RA  = 0;
  localparam int M_RB  = 1;
  localparam int M_R0  = 2;
  localparam int M_ALT = 3;
  localparam int M_WM  = 4;
  localparam int M_WA  = 5;

  bank_e cur_bank, alt_bank;

  bgrf_bank_sel u_bank_sel (
    .priv_i     (priv_i),
    .bank_sel_i (bank_sel_i),
    .cur_bank_o (cur_bank),
    .alt_bank_o (alt_bank)
  );

  logic [ADDR_W-1:0] map_addr [NUM_MAP];
  bank_e             map_bank [NUM_MAP];
  logic [PHYS_W-1:0] map_phys [NUM_MAP];

  always_comb begin
    map_addr[M_RA]  = ra_addr_i;          map_bank[M_RA]  = cur_bank;
    map_addr[M_RB]  = rb_addr_i;          map_bank[M_RB]  = cur_bank;
    map_addr[M_R0]  = '0;                 map_bank[M_R0]  = cur_bank;
    map_addr[M_ALT] = ADDR_W'(alt_addr_i); map_bank[M_ALT] = alt_bank;
    map_addr[M_WM]  = wa_addr_i;          map_bank[M_WM]  = cur_bank;
    map_addr[M_WA]  = ADDR_W'(alt_addr_i); map_bank[M_WA]  = alt_bank;
  end

  for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
    bgrf_map #(
      .NUM_LOW  (NUM_LOW),
      .NUM_HIGH (NUM_HIGH),
      .ADDR_W   (ADDR_W),
      .PHYS_W   (PHYS_W)
    ) u_map (
      .addr_i (map_addr[m]),
      .bank_i (map_bank[m]),
      .phys_o (map_phys[m])
    );
  end

  logic [NUM_WR-1:0] st_we;
  logic [PHYS_W-1:0] st_waddr [NUM_WR];
  logic [DATA_W-1:0] st_wdata [NUM_WR];
  logic [PHYS_W-1:0] st_raddr [NUM_RD];
  logic [DATA_W-1:0] st_rdata [NUM_RD];

  always_comb begin
    st_we       = {alt_we_i, we_i};
    st_waddr[0] = map_phys[M_WM];
    st_waddr[1] = map_phys[M_WA];
    st_wdata[0] = wd_i;
    st_wdata[1] = alt_wd_i;
    for (int r = 0; r < NUM_RD; r++) st_raddr[r] = map_phys[r];
  end

  bgrf_store #(
    .DATA_W   (DATA_W),
    .NUM_PHYS (NUM_PHYS),
    .PHYS_W   (PHYS_W),
    .NUM_RD   (NUM_RD),
    .NUM_WR   (NUM_WR)
  ) u_store (
    .clk_i   (clk_i),
    .we_i    (st_we),
    .waddr_i (st_waddr),
    .wdata_i (st_wdata),
    .raddr_i (st_raddr),
    .rdata_o (st_rdata)
  );

  assign ra_data_o  = st_rdata[M_RA];
  assign rb_data_o  = st_rdata[M_RB];
  assign r0_data_o  = st_rdata[M_R0];
  assign alt_data_o = st_rdata[M_ALT];
endmodule

// File: rtl/bgrf_chk.sv
module bgrf_chk
  import bgrf_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int NUM_LOW  = DEF_NUM_LOW,
  parameter int NUM_HIGH = DEF_NUM_HIGH,
  localparam int ADDR_W  = $clog2(NUM_LOW + NUM_HIGH),
  localparam int LOW_W   = $clog2(NUM_LOW)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              priv_i,
  input logic              bank_sel_i,
  input logic [ADDR_W-1:0] ra_addr_i,
  input logic [DATA_W-1:0] ra_data_o,
  input logic [ADDR_W-1:0] rb_addr_i,
  input logic [DATA_W-1:0] rb_data_o,
  input logic              we_i,
  input logic [ADDR_W-1:0] wa_addr_i,
  input logic [DATA_W-1:0] wd_i,
  input logic [DATA_W-1:0] r0_data_o,
  input logic [LOW_W-1:0]  alt_addr_i,
  input logic [DATA_W-1:0] alt_data_o,
  input logic              alt_we_i,
  input logic [DATA_W-1:0] alt_wd_i
);
  localparam logic [ADDR_W-1:0] LOW_LIM = ADDR_W'(NUM_LOW);

  logic eff;
  assign eff = priv_i & bank_sel_i;

  AST_SHARED_WRITE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(wa_addr_i) >= LOW_LIM && ra_addr_i == $past(wa_addr_i))
      |-> ra_data_o == $past(wd_i)); // R2

  AST_LOW_WRITE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && $past(wa_addr_i) < LOW_LIM && eff == $past(eff) &&
     ra_addr_i == $past(wa_addr_i))
      |-> ra_data_o == $past(wd_i)); // R1

  AST_USER_BANK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priv_i && !$past(priv_i) && !$past(we_i) && !$past(alt_we_i) && $stable(ra_addr_i))
      |-> $stable(ra_data_o)); // R4

  AST_ALT_WRITE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(alt_we_i) && eff == $past(eff) && alt_addr_i == $past(alt_addr_i))
      |-> alt_data_o == $past(alt_wd_i)); // R5

  AST_BANK_SWAP_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff != $past(eff) && !$past(we_i) && !$past(alt_we_i) &&
     ra_addr_i == ADDR_W'($past(alt_addr_i)))
      |-> ra_data_o == $past(alt_data_o)); // R3

  AST_R0_MATCHES_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == '0) |-> r0_data_o == ra_data_o); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && !$past(alt_we_i) && eff == $past(eff) && $stable(rb_addr_i))
      |-> $stable(rb_data_o)); // R10
endmodule

bind banked_regfile bgrf_chk u_bgrf_chk (.*);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        priv_i = 1'b0, bank_sel_i = 1'b0;
  logic [3:0]  ra_addr_i = '0, rb_addr_i = '0, wa_addr_i = '0;
  logic [31:0] ra_data_o, rb_data_o, r0_data_o, alt_data_o;
  logic        we_i = 1'b0, alt_we_i = 1'b0;
  logic [31:0] wd_i = '0, alt_wd_i = '0;
  logic [2:0]  alt_addr_i = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  banked_regfile u_banked_regfile (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        priv;
    logic        bank;
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{4'd1,  1'b1, 1'b1, 1'b1, 4'd3,  32'hA1A1_0003, 4'd3,  32'hA1A1_0003}, // R1
    '{4'd3,  1'b1, 1'b0, 1'b1, 4'd3,  32'hB0B0_0003, 4'd3,  32'hB0B0_0003}, // R3
    '{4'd3,  1'b1, 1'b1, 1'b0, 4'd3,  32'h0,         4'd3,  32'hA1A1_0003}, // R3
    '{4'd3,  1'b1, 1'b0, 1'b0, 4'd3,  32'h0,         4'd3,  32'hB0B0_0003}, // R3
    '{4'd1,  1'b1, 1'b1, 1'b1, 4'd9,  32'hC9C9_0009, 4'd9,  32'hC9C9_0009}, // R1
    '{4'd2,  1'b1, 1'b0, 1'b0, 4'd9,  32'h0,         4'd9,  32'hC9C9_0009}, // R2
    '{4'd2,  1'b0, 1'b1, 1'b0, 4'd9,  32'h0,         4'd9,  32'hC9C9_0009}, // R2
    '{4'd4,  1'b0, 1'b1, 1'b0, 4'd3,  32'h0,         4'd3,  32'hB0B0_0003}, // R4
    '{4'd4,  1'b0, 1'b1, 1'b1, 4'd3,  32'hD0D0_0003, 4'd3,  32'hD0D0_0003}, // R4
    '{4'd4,  1'b1, 1'b0, 1'b0, 4'd3,  32'h0,         4'd3,  32'hD0D0_0003}, // R4
    '{4'd3,  1'b1, 1'b1, 1'b0, 4'd3,  32'h0,         4'd3,  32'hA1A1_0003}, // R3
    '{4'd1,  1'b0, 1'b0, 1'b1, 4'd15, 32'hEFEF_000F, 4'd15, 32'hEFEF_000F}, // R1
    '{4'd2,  1'b1, 1'b1, 1'b0, 4'd15, 32'h0,         4'd15, 32'hEFEF_000F}, // R2
    '{4'd10, 1'b0, 1'b0, 1'b0, 4'd15, 32'h0,         4'd15, 32'hEFEF_000F}  // R10
  };

  function automatic logic [31:0] init_val(input int b, input int n);
    if (n < 8) return 32'h1000_0000 | (32'(b) << 8) | 32'(n);
    return 32'h2000_0000 | 32'(n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // fill every physical slot
    priv_i = 1'b1;
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 8; n++) begin
        bank_sel_i = b[0]; we_i = 1'b1; wa_addr_i = 4'(n); wd_i = init_val(b, n);
        step();
      end
    end
    for (int n = 8; n < 16; n++) begin
      we_i = 1'b1; wa_addr_i = 4'(n); wd_i = init_val(0, n);
      step();
    end
    we_i = 1'b0;
    bank_sel_i = 1'b1; ra_addr_i = 4'd2; rb_addr_i = 4'd10; #1;
    chk("R3 init bank1 r2", ra_data_o, init_val(1, 2));
    chk("R1 init r10 port b", rb_data_o, init_val(0, 10));

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      priv_i = VEC[i].priv; bank_sel_i = VEC[i].bank; we_i = VEC[i].we;
      wa_addr_i = VEC[i].wa; wd_i = VEC[i].wd; ra_addr_i = VEC[i].ra;
      step();
      chk($sformatf("R%0d vector %0d", VEC[i].req, i), ra_data_o, VEC[i].exp);
    end
    we_i = 1'b0;

    // R5 alternate read
    priv_i = 1'b1; bank_sel_i = 1'b0; alt_addr_i = 3'd3; #1;
    chk("R5 alt read bank1 r3", alt_data_o, 32'hA1A1_0003);
    priv_i = 1'b0; bank_sel_i = 1'b1; #1;
    chk("R5 alt read user mode", alt_data_o, 32'hA1A1_0003);
    priv_i = 1'b1; #1;
    chk("R5 alt read bank0 r3", alt_data_o, 32'hD0D0_0003);

    // R5 alternate write
    @(negedge clk_i);
    bank_sel_i = 1'b0; alt_we_i = 1'b1; alt_addr_i = 3'd5; alt_wd_i = 32'h5555_0005;
    step();
    alt_we_i = 1'b0; ra_addr_i = 4'd5; #1;
    chk("R5 alt write spares bank0", ra_data_o, init_val(0, 5));
    bank_sel_i = 1'b1; #1;
    chk("R5 alt write lands bank1", ra_data_o, 32'h5555_0005);

    // R9 simultaneous writes
    @(negedge clk_i);
    we_i = 1'b1; wa_addr_i = 4'd6; wd_i = 32'h6666_1006;
    alt_we_i = 1'b1; alt_addr_i = 3'd6; alt_wd_i = 32'h7777_0006;
    step();
    we_i = 1'b0; alt_we_i = 1'b0; ra_addr_i = 4'd6; #1;
    chk("R9 main write bank1 r6", ra_data_o, 32'h6666_1006);
    bank_sel_i = 1'b0; #1;
    chk("R9 alt write bank0 r6", ra_data_o, 32'h7777_0006);

    // R6 register 0 output
    ra_addr_i = 4'd4; #1;
    chk("R6 r0 bank0", r0_data_o, init_val(0, 0));
    bank_sel_i = 1'b1; #1;
    chk("R6 r0 bank1", r0_data_o, init_val(1, 0));
    priv_i = 1'b0; #1;
    chk("R6 r0 user mode", r0_data_o, init_val(0, 0));

    // R7 read during write
    @(negedge clk_i);
    priv_i = 1'b1; bank_sel_i = 1'b0;
    we_i = 1'b1; wa_addr_i = 4'd9; wd_i = 32'h9999_0009; ra_addr_i = 4'd9; #1;
    chk("R7 old value same cycle", ra_data_o, 32'hC9C9_0009);
    step();
    we_i = 1'b0; #1;
    chk("R7 new value next cycle", ra_data_o, 32'h9999_0009);
    rb_addr_i = 4'd9; #1;
    chk("R1 port b after write", rb_data_o, 32'h9999_0009);

    // R8 reset keeps contents
    @(negedge clk_i);
    rst_ni = 1'b0;
    step(); step();
    chk("R8 during reset r9", ra_data_o, 32'h9999_0009);
    rst_ni = 1'b1; bank_sel_i = 1'b1; ra_addr_i = 4'd3; #1;
    chk("R8 after reset bank1 r3", ra_data_o, 32'hA1A1_0003);
    bank_sel_i = 1'b0; #1;
    chk("R8 after reset bank0 r3", ra_data_o, 32'hD0D0_0003);

    done = 1'b1;
    finish_run();
  end
endmodule